// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous static RAM. The full-size part has 17 address bits and 18 data bits, split into two 9-bit byte lanes. The model registers its address, chip selects, read/write strobe and per-lane write enables on the rising clock edge. Reads are flow-through: the word at the registered address reaches the data output during the cycle that follows the edge, with no output register. Writes take their data one enabled edge after the address. A read can therefore follow a write in the very next cycle with no idle cycle between them. The write still in flight is held in a pending register, and reads of that address are served from it.

An active-low clock enable stalls the whole block. A load/advance input either starts a new access or steps a four-beat burst. The burst steps through the low two address bits in linear wrapping order or in interleaved order, chosen by a mode input. The tri-state data bus is modelled as separate input, output and output-enable ports. A sleep input freezes the block and disables the output while keeping the stored contents. The address width defaults to a small value so that the array stays light; set `ADDR_W` to 17 for the full 128K-word array.

Top module: `nbl_sram`

## Requirements
- R1: While `rst` is high at an edge, the following cycle has `dout_oe` low and no write pending.
- R2: An access is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0 at a load edge (`adv`=0). Any other combination is a deselect: `dout_oe` is low in the next cycle, no array word changes, and advance edges that follow stay deselected.
- R3: After an enabled load edge with `we_n`=1, `dout` shows the word at `addr` during the next cycle, with `dout_oe` high.
- R4: For a write loaded with `we_n`=0, `din` is taken at the next enabled edge. The cycle after the write's load edge may already be a new read or write.
- R5: A read of the address whose write data is still pending returns the pending data in the enabled lanes and the array contents in the other lanes.
- R6: `bw_n[0]`=0 enables data bits 8:0 and `bw_n[1]`=0 enables bits 17:9. Both are sampled with the write's address, and a disabled lane keeps its old value.
- R7: With `cen_n`=1, an edge changes no state. The output holds, the burst position holds, and no `din` is taken.
- R8: With `burst_mode` sampled 0 at load, each advance edge (`adv`=1) steps the low two address bits as start+beat mod 4. The upper address bits and the read/write kind are held.
- R9: With `burst_mode` sampled 1 at load, the low two address bits of beat k are start XOR k.
- R10: `sleep`=1 is allowed only while deselected. During sleep, edges are ignored and `dout_oe` is low. Array contents and any pending write survive.
- R11: `dout_oe` is low during the cycle that follows a write load or write advance edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of control state |
| cen_n | input | 1 | Clock enable, active low; high stalls |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 1 = advance burst, 0 = load new access |
| we_n | input | 1 | 0 = write, 1 = read (sampled at load) |
| bw_n | input | LANES | Per-lane write enables, active low |
| burst_mode | input | 1 | 0 = linear burst, 1 = interleaved burst |
| sleep | input | 1 | Sleep request, only while deselected |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Write data, one enabled edge after address |
| dout | output | LANES*LANE_W | Read data, flow-through |
| dout_oe | output | 1 | Output enable of the data bus |

## Verification
Assertions check on every cycle that a stall holds the registered access and the burst position. They also check that each advance edge steps the beat by one, that a write cycle always leaves data pending, and that a deselect or reset turns the bus off. They also check that sleep arrives only while deselected and keeps the bus off. Only the bench scenarios can show that the right words come back. This covers the merge of pending data per lane after back-to-back write/read pairs, the exact burst address orders for every start offset in both modes, and the fact that no word changes after a deselected, stalled or sleeping write attempt.

// File: rtl/nbl_pkg.sv
package nbl_pkg;

  typedef enum logic {
    BURST_LINEAR     = 1'b0,
    BURST_INTERLEAVE = 1'b1
  } burst_mode_e;

  // low two address bits for a given burst beat
  function automatic logic [1:0] burst_low(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input burst_mode_e  order);
    if (order == BURST_INTERLEAVE) return start ^ beat;
    else                           return 2'(start + beat);
  endfunction

endpackage

// File: rtl/nbl_array.sv
module nbl_array #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [LANES-1:0]          wlane,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // one narrow memory per lane so each lane has its own write enable
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wlane[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/nbl_burst_ctr.sv
module nbl_burst_ctr
  import nbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic       step,
  input  logic [1:0] start,
  input  logic       mode,
  output logic [1:0] low
);
  logic [1:0]  start_q;
  logic [1:0]  beat_q;
  burst_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      mode_q  <= BURST_LINEAR;
    end else if (en) begin
      if (load) begin
        start_q <= start;
        beat_q  <= '0;
        mode_q  <= burst_mode_e'(mode);
      end else if (step) begin
        beat_q <= 2'(beat_q + 2'd1);
      end
    end
  end

  assign low = burst_low(start_q, beat_q, mode_q);

  // R8: every enabled advance moves exactly one beat
  p_burst_step_r8: assert property (@(posedge clk) disable iff (rst)
    (en && !load && step) |=> (beat_q == 2'($past(beat_q) + 2'd1)));

  // R7: a stalled edge keeps the burst position
  p_burst_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(beat_q) && $stable(start_q)));

endmodule

// File: rtl/nbl_write_pipe.sv
module nbl_write_pipe #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en,
  input  logic                      cap,
  input  logic [ADDR_W-1:0]         cap_addr,
  input  logic [LANES*LANE_W-1:0]   cap_data,
  input  logic [LANES-1:0]          cap_lanes,
  output logic                      commit,
  output logic [ADDR_W-1:0]         com_addr,
  output logic [LANES*LANE_W-1:0]   com_data,
  output logic [LANES-1:0]          com_lanes,
  output logic                      pend_v,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [LANES*LANE_W-1:0]   arr_data,
  output logic [LANES*LANE_W-1:0]   rd_data
);
  logic [ADDR_W-1:0]       pend_addr;
  logic [LANES*LANE_W-1:0] pend_data;
  logic [LANES-1:0]        pend_lanes;
  logic                    hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_lanes <= '0;
    end else if (en && cap) begin
      pend_v     <= 1'b1;
      pend_addr  <= cap_addr;
      pend_data  <= cap_data;
      pend_lanes <= cap_lanes;
    end
  end

  // the older pending word drains into the array when a newer one arrives
  assign commit    = en && cap && pend_v;
  assign com_addr  = pend_addr;
  assign com_data  = pend_data;
  assign com_lanes = pend_lanes;

  assign hit = pend_v && (pend_addr == rd_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rd_data[g*LANE_W +: LANE_W] = (hit && pend_lanes[g]) ?
        pend_data[g*LANE_W +: LANE_W] : arr_data[g*LANE_W +: LANE_W];
  end

  // R4: a write data edge always leaves a pending word
  p_pend_load_r4: assert property (@(posedge clk) disable iff (rst)
    (en && cap) |=> pend_v);

  // R10/R7: pending word survives an ignored edge
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(pend_v) && $stable(pend_data) && $stable(pend_addr)));

endmodule

// File: rtl/nbl_sram.sv
module nbl_sram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cen_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    adv,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    burst_mode,
  input  logic                    sleep,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int HI_W   = ADDR_W - 2;

  logic              en;
  logic              selected;
  logic              load;
  logic              act_q;
  logic              wr_q;
  logic [HI_W-1:0]   base_q;
  logic [LANES-1:0]  bw_q;
  logic [1:0]        low;
  logic [ADDR_W-1:0] addr_q;

  logic              commit;
  logic [ADDR_W-1:0] com_addr;
  logic [DATA_W-1:0] com_data;
  logic [LANES-1:0]  com_lanes;
  logic              pend_v;
  logic [DATA_W-1:0] arr_data;
  logic [DATA_W-1:0] rd_data;

  assign en       = !cen_n && !sleep;
  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign load     = !adv;

  // access registers: load captures a new access, advance keeps it
  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      bw_q   <= '0;
    end else if (en) begin
      if (load) begin
        act_q <= selected;
        if (selected) begin
          wr_q   <= !we_n;
          base_q <= addr[ADDR_W-1:2];
          bw_q   <= ~bw_n;
        end
      end else if (act_q) begin
        bw_q <= ~bw_n;
      end
    end
  end

  nbl_burst_ctr u_burst (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .load  (load && selected),
    .step  (act_q),
    .start (addr[1:0]),
    .mode  (burst_mode),
    .low   (low)
  );

  assign addr_q = {base_q, low};

  nbl_write_pipe #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_wpipe (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .cap       (act_q && wr_q),
    .cap_addr  (addr_q),
    .cap_data  (din),
    .cap_lanes (bw_q),
    .commit    (commit),
    .com_addr  (com_addr),
    .com_data  (com_data),
    .com_lanes (com_lanes),
    .pend_v    (pend_v),
    .rd_addr   (addr_q),
    .arr_data  (arr_data),
    .rd_data   (rd_data)
  );

  nbl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk   (clk),
    .we    (commit),
    .waddr (com_addr),
    .wdata (com_data),
    .wlane (com_lanes),
    .raddr (addr_q),
    .rdata (arr_data)
  );

  assign dout_oe = act_q && !wr_q && !sleep;
  assign dout    = dout_oe ? rd_data : '0;

  // R1: reset leaves the bus off and nothing pending
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!dout_oe && !pend_v));

  // R2: a deselecting load turns the bus off next cycle
  p_desel_off_r2: assert property (@(posedge clk) disable iff (rst)
    (en && load && !selected) |=> !dout_oe);

  // R7: stall keeps the registered access
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> ($stable(act_q) && $stable(wr_q) && $stable(addr_q)));

  // R10: sleep only while deselected, and the bus stays off
  p_sleep_desel_r10: assert property (@(posedge clk) disable iff (rst)
    sleep |-> (!act_q && !dout_oe));

  // R11: a write access never drives the bus in the next cycle
  p_write_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (en && load && selected && !we_n) |=> !dout_oe);

endmodule

// File: tb/tb_nbl_sram.sv
module tb_nbl_sram;
  localparam int AW = 6;
  localparam int DW = 18;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          cen_n, sel_a_n, sel_b, sel_c_n, adv, we_n, burst_mode, sleep;
  logic [1:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_oe;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] ref_mem [N];
  logic [DW-1:0] next_din = '0;

  always #10 clk = ~clk;

  nbl_sram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) dut (
    .clk(clk), .rst(rst), .cen_n(cen_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .adv(adv), .we_n(we_n), .bw_n(bw_n),
    .burst_mode(burst_mode), .sleep(sleep), .addr(addr), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 2731 + salt * 977 + 341) ^ (a << 11));
  endfunction

  function automatic logic [AW-1:0] bseq(input logic [AW-1:0] a0, input int k, input logic m);
    logic [1:0] s;
    s = a0[1:0];
    return {a0[AW-1:2], (m ? (s ^ 2'(k)) : 2'(s + 2'(k)))};
  endfunction

  task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] bwn);
    if (!bwn[0]) ref_mem[a][8:0]  = d[8:0];
    if (!bwn[1]) ref_mem[a][17:9] = d[17:9];
  endtask

  // one clock: inputs set at negedge, outputs sampled 1 ns after the edge
  task automatic drive(input logic c_n, input logic s1, input logic s2, input logic s3,
                       input logic a_v, input logic w_n, input logic [1:0] b_n,
                       input logic [AW-1:0] ad, input logic md, input logic slp,
                       input logic [DW-1:0] wd);
    @(negedge clk);
    cen_n = c_n; sel_a_n = s1; sel_b = s2; sel_c_n = s3; adv = a_v; we_n = w_n;
    bw_n = b_n; addr = ad; burst_mode = md; sleep = slp;
    if (c_n || slp) din = ~next_din;
    else begin
      din = next_din;
      next_din = wd;
    end
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic e_oe, input logic [DW-1:0] e_d);
    checks++;
    if (dout_oe !== e_oe || (e_oe && dout !== e_d)) begin
      errors++;
      $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h", req, dout_oe, dout, e_oe, e_d);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] bwn);
    drive(0, 0, 1, 0, 0, 0, bwn, a, 0, 0, d);
    model_wr(a, d, bwn);
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic m);
    drive(0, 0, 1, 0, 0, 1, 2'b11, a, m, 0, '0);
  endtask
  task automatic nop();
    drive(0, 1, 1, 0, 0, 1, 2'b11, '0, 0, 0, '0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1; cen_n = 0; sel_a_n = 1; sel_b = 0; sel_c_n = 1; adv = 0; we_n = 1;
    bw_n = 2'b11; burst_mode = 0; sleep = 0; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", 0, '0);
    @(negedge clk); rst = 0;

    // R4 back-to-back writes over the whole array; R11 bus quiet in write cycles
    for (int a = 0; a < N; a++) begin
      wr(AW'(a), pat(a, 0), 2'b00);
      chk("R11 write cycle bus off", 0, '0);
    end
    nop();
    // R3 flow-through reads
    for (int a = 0; a < N; a++) begin
      rd(AW'(a), 0);
      chk("R3 read", 1, ref_mem[a]);
    end

    // R5 write immediately followed by read of the same word
    for (int a = 0; a < N; a += 3) begin
      wr(AW'(a), pat(a, 1), 2'b00);
      rd(AW'(a), 0);
      chk("R5 pending bypass", 1, ref_mem[a]);
    end

    // R6 single-lane writes, bypassed and after commit
    for (int a = 0; a < 8; a++) begin
      wr(AW'(a), pat(a, 2), (a % 2 == 0) ? 2'b10 : 2'b01);
      rd(AW'(a), 0);
      chk("R6 lane merge bypass", 1, ref_mem[a]);
    end
    wr(AW'(40), pat(40, 3), 2'b11);
    nop();
    wr(AW'(41), pat(41, 3), 2'b00);
    nop();
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), 0);
      chk("R6 lane after commit", 1, ref_mem[a]);
    end
    rd(AW'(40), 0);
    chk("R6 no lane enabled", 1, ref_mem[40]);

    // R8 / R9 read bursts from every start offset
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a0;
        a0 = AW'(20 + s);
        rd(a0, m[0]);
        chk(m ? "R9 interleave beat0" : "R8 linear beat0", 1, ref_mem[a0]);
        for (int k = 1; k < 4; k++) begin
          drive(0, 0, 1, 0, 1, 0, 2'b11, ~a0, ~m[0], 0, '0);
          chk(m ? "R9 interleave beat" : "R8 linear beat", 1, ref_mem[bseq(a0, k, m[0])]);
        end
      end
    end

    // R8 write burst, linear from offset 2
    begin
      logic [AW-1:0] a0;
      a0 = AW'(34);
      wr(a0, pat(0, 7), 2'b00);
      for (int k = 1; k < 4; k++) begin
        drive(0, 0, 1, 0, 1, 1, 2'b00, '0, 1, 0, pat(k, 7));
        model_wr(bseq(a0, k, 0), pat(k, 7), 2'b00);
        chk("R8 write burst bus off", 0, '0);
      end
      nop();
      for (int k = 0; k < 4; k++) begin
        rd(bseq(a0, k, 0), 0);
        chk("R8 write burst readback", 1, ref_mem[bseq(a0, k, 0)]);
      end
    end

    // R2 deselect combinations with a write attempt, then advance
    for (int c = 0; c < 3; c++) begin
      drive(0, c == 0, c != 1, c == 2, 0, 0, 2'b00, AW'(50), 0, 0, 18'h3ffff);
      chk("R2 deselect bus off", 0, '0);
      drive(0, 0, 1, 0, 1, 1, 2'b11, AW'(50), 0, 0, 18'h3ffff);
      chk("R2 advance stays deselected", 0, '0);
    end
    nop();
    rd(AW'(50), 0);
    chk("R2 deselected write ignored", 1, ref_mem[50]);

    // R7 stall during a read burst
    rd(AW'(8), 0);
    chk("R7 before stall", 1, ref_mem[8]);
    for (int i = 0; i < 2; i++) begin
      drive(1, 0, 1, 0, 1, 0, 2'b00, AW'(60), 1, 0, '0);
      chk("R7 stall holds output", 1, ref_mem[8]);
    end
    drive(0, 0, 1, 0, 1, 1, 2'b11, '0, 0, 0, '0);
    chk("R7 burst resumes one beat", 1, ref_mem[9]);

    // R7 stall between write address and data
    wr(AW'(12), pat(12, 9), 2'b00);
    drive(1, 0, 1, 0, 0, 0, 2'b00, AW'(13), 0, 0, '0);
    rd(AW'(12), 0);
    chk("R7 write data after stall", 1, ref_mem[12]);

    // R10 sleep with pending write and selected write attempts
    wr(AW'(30), pat(30, 5), 2'b00);
    nop();
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 1, 0, 0, 0, 2'b00, AW'(31), 0, 1, 18'h15555);
      chk("R10 sleep bus off", 0, '0);
    end
    nop();
    rd(AW'(31), 0);
    chk("R10 sleep write ignored", 1, ref_mem[31]);
    rd(AW'(30), 0);
    chk("R10 pending survives sleep", 1, ref_mem[30]);

    // final sweep of the whole array
    wr(AW'(63), ref_mem[63], 2'b00);
    nop();
    for (int a = 0; a < N; a++) begin
      rd(AW'(a), 0);
      chk("R4 final contents", 1, ref_mem[a]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule